// File: doc/BRIEF.md
# SPI Register Slave with Deferred Reply

This block is the serial control front end of a multi-channel output driver. A controller drives 16-bit command frames into it while chip select is low. The block collects the frame and acts on it when chip select rises. It writes or reads an 8-bit register in a small file, or answers a diagnosis request. The answer to each command does not appear in the frame that carried it. It is shifted out during the next frame the controller starts, so a controller that reads a register sends the read and then any further frame to collect the value.

The block checks every frame before acting on it. A frame whose clock count is not a multiple of eight, or that has fewer than sixteen clocks, is dropped. A command with an illegal prefix or an unused address is refused. In either case the next reply is a diagnosis word carrying a flag that names the fault. After a power-on reset, or after a software reset command, the first reply carries a reset flag.

Frames longer than sixteen clocks are allowed, so that several devices can share one chip select in a chain. The block acts on the last sixteen bits it received. Once its own sixteen reply bits have gone out, it passes its input through to its output with a delay of sixteen bits. SPI inputs are taken to be already synchronous to `clk`. Each SCLK level is held for at least two `clk` cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset `sdo_oe` is 0 and every register reads 0. The first reply after reset is exactly 16'h2000, the diagnosis word with only the reset flag (bit 13) set.
- R2: A frame is accepted only if the number of SCLK rising edges while `cs_n` is low is a multiple of 8 and at least 16. Any other frame changes no register. Its next reply is the diagnosis word with the frame-error flag (bit 14) set.
- R3: SDI is sampled on SCLK rising edges and SDO changes after SCLK falling edges, most significant bit first. The reply to a frame is shifted out in the following frame. `sdo_oe` is 1 while `cs_n` is low and 0 while it is high.
- R4: The diagnosis word is built at the chip-select rise that ends the command frame. Bit 15 is 0, bit 14 is the frame-error flag, bit 13 is the reset flag, bit 12 is the syntax flag, and bits 11:0 are `diag_i` as sampled at that moment.
- R5: A write frame has bits 15:14 = 10, bank index in bits 13:10, bank number in bits 9:8 and data in bits 7:0. With index below N_REGS and bank below N_BANKS, it stores the data, and its reply is the diagnosis word with all three flags clear.
- R6: A read frame has bits 15:14 = 01 and bits 1:0 = 10, with the same address fields. For a valid address its reply is 10, the echoed index and bank fields, and then the register content.
- R7: Any frame with bit 15 = 0 and bits 1:0 = 01 is a diagnosis read. Its reply is the diagnosis word with all flags clear.
- R8: Bits 15:14 = 11 are a syntax error. So is any frame that is neither a diagnosis read nor a read with bits 15:14 = 01 and bits 1:0 = 10. So is a read or write to an unused address, except the reset address of R9. A syntax error changes no register, and its reply is the diagnosis word with the syntax flag set.
- R9: A write to index 15 in bank 3 is a software reset, whatever the data. It clears every register, and its reply is the diagnosis word with the reset flag set.
- R10: In a frame longer than 16 clocks, the bits after the first 16 SDO bits are the SDI bits of the same frame delayed by 16 clocks. The command acted on is the last 16 bits received.
- R11: `regs_o` presents register (bank b, index i) at bits [(b*N_REGS+i)*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| diag_i | input | 12 | Live fault bits placed in the diagnosis word |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| regs_o | output | N_BANKS*N_REGS*8 (160) | Flattened register file contents |

## Verification
The assertions assume that `cs_n`, `sclk` and `sdi` come from a single controller clocked with `clk`. They also assume that SCLK never has an edge in the same cycle as a chip-select edge, and that SCLK is low whenever chip select changes. The bench drives every SPI level from the negative edge of `clk` and holds each SCLK phase for four clock cycles. It leaves four cycles between chip-select edges and the nearest SCLK edge, and it samples SDO in the middle of each low phase, just before raising SCLK.

// File: rtl/spi_rf_pkg.sv
// Package: shared frame constants and decoded command type for the SPI
// register slave. Field positions here follow the command frame layout.
package spi_rf_pkg;

    localparam int FRAME_W = 16;
    localparam int BYTE_W  = 8;
    localparam int DIAG_W  = FRAME_W - 4;
    localparam int A0_W    = 4;
    localparam int A1_W    = 2;

    // Flag positions inside the diagnosis word
    localparam int FLAG_FRAME = FRAME_W - 2;
    localparam int FLAG_RST   = FRAME_W - 3;
    localparam int FLAG_SYN   = FRAME_W - 4;

    typedef enum logic [2:0] {
        OP_DIAG,
        OP_WRITE,
        OP_READ,
        OP_SRST,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [A0_W-1:0]    a0;
        logic [A1_W-1:0]    a1;
        logic [BYTE_W-1:0]  data;
    } cmd_t;

endpackage

// File: rtl/spi_frame_port.sv
// spi_frame_port: serial shifter and frame-length check.
// Assumes cs_n/sclk/sdi are synchronous to clk, SCLK is idle low and
// each SCLK level lasts at least two clk cycles. Loads the pending reply at
// chip-select fall, shifts the reply out (then SDI delayed by FRAME_W bits),
// and flags the chip-select rise together with the length check result.
module spi_frame_port
    import spi_rf_pkg::*;
#(
    parameter int WORD_W = FRAME_W,
    parameter int UNIT_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] reply_i,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              frame_end,
    output logic              frame_ok,
    output logic [WORD_W-1:0] cmd_o
);

    localparam int CW        = $clog2(UNIT_W);
    localparam int MIN_UNITS = WORD_W / UNIT_W;
    localparam int BCW       = $clog2(MIN_UNITS + 1);
    localparam logic [CW-1:0]  LAST_BIT  = CW'(UNIT_W - 1);
    localparam logic [BCW-1:0] UNITS_MIN = BCW'(MIN_UNITS);

    logic              sclk_q;
    logic              cs_q;
    logic              frame_start;
    logic              rise;
    logic              fall;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] tx_q;
    logic [CW-1:0]     bit_q;
    logic [BCW-1:0]    unit_q;

    // Edge detection of chip select and serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign frame_start = !cs_n && cs_q;
    assign frame_end   = cs_n && !cs_q;
    assign rise        = !cs_n && sclk && !sclk_q;
    assign fall        = !cs_n && !sclk && sclk_q;

    // Receive shifter: SDI into the low end on each rising SCLK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise) begin
            rx_q <= {rx_q[WORD_W-2:0], sdi};
        end
    end

    // Transmit shifter: reply load at frame start, refill from receive side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (frame_start) begin
            tx_q <= reply_i;
        end else if (fall) begin
            tx_q <= {tx_q[WORD_W-2:0], rx_q[0]};
        end
    end

    // Clock counting: bit position in unit and saturating unit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            unit_q <= '0;
        end else if (frame_start) begin
            bit_q  <= '0;
            unit_q <= '0;
        end else if (rise) begin
            if (bit_q == LAST_BIT) begin
                bit_q <= '0;
                if (unit_q != UNITS_MIN) begin
                    unit_q <= unit_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Output enable registered from chip select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_oe <= 1'b0;
        end else begin
            sdo_oe <= !cs_n;
        end
    end

    assign sdo      = tx_q[WORD_W-1];
    assign frame_ok = (bit_q == '0) && (unit_q == UNITS_MIN);
    assign cmd_o    = rx_q;

endmodule

// File: rtl/spi_cmd_decode.sv
// spi_cmd_decode: classifies a received 16-bit frame into an operation and
// extracts its fields. Purely combinational; assumes the frame is complete.
// Addresses outside the configured bank/index range become OP_BAD, except
// the dedicated software reset address on a write.
module spi_cmd_decode
    import spi_rf_pkg::*;
#(
    parameter int               N_REGS  = 10,
    parameter int               N_BANKS = 2,
    parameter logic [A0_W-1:0]  SRST_A0 = 4'hF,
    parameter logic [A1_W-1:0]  SRST_A1 = 2'b11
) (
    input  logic [FRAME_W-1:0] frame_i,
    output cmd_t               cmd_o
);

    logic [1:0]        head;
    logic [1:0]        tail;
    logic [A0_W-1:0]   a0;
    logic [A1_W-1:0]   a1;
    logic              addr_ok;
    logic              srst_hit;

    assign head     = frame_i[FRAME_W-1 -: 2];
    assign tail     = frame_i[1:0];
    assign a0       = frame_i[FRAME_W-3 -: A0_W];
    assign a1       = frame_i[FRAME_W-3-A0_W -: A1_W];
    assign addr_ok  = ({1'b0, a0} < (A0_W+1)'(N_REGS)) &&
                      ({1'b0, a1} < (A1_W+1)'(N_BANKS));
    assign srst_hit = (a0 == SRST_A0) && (a1 == SRST_A1);

    // Operation classification in priority order
    always_comb begin
        cmd_o.a0   = a0;
        cmd_o.a1   = a1;
        cmd_o.data = frame_i[BYTE_W-1:0];
        if (head == 2'b10) begin
            if (srst_hit)     cmd_o.op = OP_SRST;
            else if (addr_ok) cmd_o.op = OP_WRITE;
            else              cmd_o.op = OP_BAD;
        end else if (head == 2'b11) begin
            cmd_o.op = OP_BAD;
        end else if (tail == 2'b01) begin
            cmd_o.op = OP_DIAG;
        end else if (head == 2'b01 && tail == 2'b10 && addr_ok) begin
            cmd_o.op = OP_READ;
        end else begin
            cmd_o.op = OP_BAD;
        end
    end

endmodule

// File: rtl/spi_reg_bank.sv
// spi_reg_bank: N_BANKS x N_REGS file of 8-bit registers with one write
// port, one combinational read port and a synchronous clear. Assumes the
// caller only presents in-range addresses with we asserted.
module spi_reg_bank
    import spi_rf_pkg::*;
#(
    parameter int N_REGS  = 10,
    parameter int N_BANKS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic                             clr,
    input  logic [A0_W-1:0]                  a0,
    input  logic [A1_W-1:0]                  a1,
    input  logic [BYTE_W-1:0]                wdata,
    output logic [BYTE_W-1:0]                rdata,
    output logic [N_BANKS*N_REGS*BYTE_W-1:0] regs_o
);

    logic [BYTE_W-1:0] mem [N_BANKS][N_REGS];

    // Storage: reset, software clear, addressed write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int b = 0; b < N_BANKS; b++) begin
                for (int i = 0; i < N_REGS; i++) begin
                    mem[b][i] <= '0;
                end
            end
        end else if (we) begin
            for (int b = 0; b < N_BANKS; b++) begin
                for (int i = 0; i < N_REGS; i++) begin
                    if (a1 == A1_W'(b) && a0 == A0_W'(i)) begin
                        mem[b][i] <= wdata;
                    end
                end
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            for (int i = 0; i < N_REGS; i++) begin
                if (a1 == A1_W'(b) && a0 == A0_W'(i)) begin
                    rdata = mem[b][i];
                end
            end
        end
    end

    for (genvar gb = 0; gb < N_BANKS; gb++) begin : g_bank
        for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
            assign regs_o[(gb*N_REGS+gi)*BYTE_W +: BYTE_W] = mem[gb][gi];
        end
    end

endmodule

// File: rtl/spi_reg_slave.sv
// spi_reg_slave: SPI command slave with a reply deferred to the next frame.
// Assumes SPI inputs are synchronous to clk. Acts on a frame at the
// chip-select rise: writes, reads, diagnosis reads and software reset.
// Length and syntax faults are refused and flagged in the next reply.
module spi_reg_slave
    import spi_rf_pkg::*;
#(
    parameter int N_REGS  = 10,
    parameter int N_BANKS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cs_n,
    input  logic                             sclk,
    input  logic                             sdi,
    input  logic [DIAG_W-1:0]                diag_i,
    output logic                             sdo,
    output logic                             sdo_oe,
    output logic [N_BANKS*N_REGS*BYTE_W-1:0] regs_o
);

    localparam int REGS_W = N_BANKS * N_REGS * BYTE_W;
    localparam logic [FRAME_W-1:0] RST_REPLY = FRAME_W'(1) << FLAG_RST;

    logic               frame_end;
    logic               frame_ok;
    logic [FRAME_W-1:0] cmd_w;
    logic [FRAME_W-1:0] reply_q;
    logic [BYTE_W-1:0]  rdata;
    logic               accept;
    cmd_t               dec;

    spi_frame_port #(.WORD_W(FRAME_W), .UNIT_W(BYTE_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .reply_i   (reply_q),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .cmd_o     (cmd_w)
    );

    spi_cmd_decode #(.N_REGS(N_REGS), .N_BANKS(N_BANKS)) u_dec (
        .frame_i (cmd_w),
        .cmd_o   (dec)
    );

    assign accept = frame_end && frame_ok;

    spi_reg_bank #(.N_REGS(N_REGS), .N_BANKS(N_BANKS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (accept && dec.op == OP_WRITE),
        .clr    (accept && dec.op == OP_SRST),
        .a0     (dec.a0),
        .a1     (dec.a1),
        .wdata  (dec.data),
        .rdata  (rdata),
        .regs_o (regs_o)
    );

    // Reply builder: captures the answer at the end of each frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_q <= RST_REPLY;
        end else if (frame_end) begin
            if (!frame_ok) begin
                reply_q <= {4'b0100, diag_i};
            end else begin
                unique case (dec.op)
                    OP_DIAG, OP_WRITE: reply_q <= {4'b0000, diag_i};
                    OP_SRST:           reply_q <= {4'b0010, diag_i};
                    OP_READ:           reply_q <= {2'b10, dec.a0, dec.a1, rdata};
                    default:           reply_q <= {4'b0001, diag_i};
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_reg_slave_chk.sv
// spi_reg_slave_chk: temporal checks on the SPI register slave, bound to it.
// Assumes SCLK and chip-select edges never share a clk cycle.
module spi_reg_slave_chk #(
    parameter int REGS_W = 160
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo_oe,
    input logic              frame_end,
    input logic              frame_ok,
    input logic [15:0]       cmd,
    input logic [15:0]       reply_q,
    input logic [REGS_W-1:0] regs_o
);

    a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    a_r3_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> sdo_oe);

    a_r2_bad_len_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_ok) |=> $stable(regs_o));

    a_r2_bad_len_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_ok) |=> (reply_q[15:12] == 4'b0100));

    a_r5_regs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(regs_o));

    a_r8_bad_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_ok && cmd[15:14] == 2'b11)
            |=> ($stable(regs_o) && reply_q[15:12] == 4'b0001));

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_ok && cmd[15:8] == 8'hBF)
            |=> (regs_o == '0 && reply_q[15:12] == 4'b0010));

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.REGS_W(REGS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_oe    (sdo_oe),
    .frame_end (frame_end),
    .frame_ok  (frame_ok),
    .cmd       (cmd_w),
    .reply_q   (reply_q),
    .regs_o    (regs_o)
);

// File: tb/test_spi_reg_slave.sv
// Directed bench for spi_reg_slave: one task per scenario, reference model
// built from the requirements only.
module test_spi_reg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SPI   = 4;
    localparam int NR = 10;
    localparam int NB = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cs_n;
    logic              sclk;
    logic              sdi;
    logic [11:0]       diag_i;
    logic              sdo;
    logic              sdo_oe;
    logic [NB*NR*8-1:0] regs_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_reply;
    logic [7:0]  mreg [NB][NR];
    logic [31:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_slave #(.N_REGS(NR), .N_BANKS(NB)) i_spi_reg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .diag_i (diag_i),
        .sdo    (sdo),
        .sdo_oe (sdo_oe),
        .regs_o (regs_o)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SPI transaction of n bits, MSB first; returns SDO bits
    task automatic xfer(input logic [31:0] d, input int n, output logic [31:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF_SPI);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = d[i];
            wait_clk(HALF_SPI);
            rx = {rx[30:0], sdo};
            sclk = 1'b1;
            wait_clk(HALF_SPI);
            sclk = 1'b0;
        end
        wait_clk(HALF_SPI);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    // Reference model of a completed frame (R2, R4..R9)
    task automatic model(input logic [31:0] d, input int n);
        logic [15:0] c;
        logic [3:0]  a0;
        logic [1:0]  a1;
        logic        ok_addr;
        c  = d[15:0];
        a0 = c[13:10];
        a1 = c[9:8];
        ok_addr = (a0 < NR) && (a1 < NB);
        if ((n % 8) != 0 || n < 16) begin
            exp_reply = {4'b0100, diag_i};
        end else if (c[15:14] == 2'b10) begin
            if (a0 == 4'hF && a1 == 2'b11) begin
                for (int b = 0; b < NB; b++)
                    for (int i = 0; i < NR; i++) mreg[b][i] = 8'h00;
                exp_reply = {4'b0010, diag_i};
            end else if (ok_addr) begin
                mreg[a1][a0] = c[7:0];
                exp_reply = {4'b0000, diag_i};
            end else begin
                exp_reply = {4'b0001, diag_i};
            end
        end else if (c[15:14] == 2'b11) begin
            exp_reply = {4'b0001, diag_i};
        end else if (c[1:0] == 2'b01) begin
            exp_reply = {4'b0000, diag_i};
        end else if (c[15:14] == 2'b01 && c[1:0] == 2'b10 && ok_addr) begin
            exp_reply = {2'b10, a0, a1, mreg[a1][a0]};
        end else begin
            exp_reply = {4'b0001, diag_i};
        end
    endtask

    task automatic chk_regs(input string req);
        logic [NB*NR*8-1:0] e;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < NR; i++) e[(b*NR+i)*8 +: 8] = mreg[b][i];
        checks++;
        if (regs_o !== e) begin
            errors++;
            $display("FAIL %s regs actual=%h expected=%h", req, regs_o, e);
        end
    endtask

    // Run a frame, check its reply against the pending expectation, update model
    task automatic frame(input logic [31:0] d, input int n, input string req);
        logic [31:0] ev;
        logic [31:0] av;
        xfer(d, n, got);
        if (n >= 16) begin
            av = {16'h0, got[n-1 -: 16]};
            ev = {16'h0, exp_reply};
        end else begin
            av = got & ((32'h1 << n) - 1);
            ev = {16'h0, exp_reply} >> (16 - n);
        end
        chk(av == ev, req, av, ev);
        model(d, n);
        chk_regs(req);
    endtask

    function automatic logic [15:0] wr(input logic [3:0] a0, input logic [1:0] a1,
                                        input logic [7:0] v);
        return {2'b10, a0, a1, v};
    endfunction

    function automatic logic [15:0] rd(input logic [3:0] a0, input logic [1:0] a1);
        return {2'b01, a0, a1, 6'b101010, 2'b10};
    endfunction

    task automatic t_reset;
        chk(sdo_oe == 1'b0, "R1 oe", {31'h0, sdo_oe}, 32'h0);
        chk(regs_o == '0, "R1 regs", regs_o[31:0], 32'h0);
        chk(exp_reply == 16'h2000, "R1 model", {16'h0, exp_reply}, 32'h2000);
        frame(32'h0001, 16, "R1 first reply");
    endtask

    task automatic t_oe;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(3);
        chk(sdo_oe == 1'b1, "R3 oe during frame", {31'h0, sdo_oe}, 32'h1);
        cs_n = 1'b1;
        wait_clk(3);
        chk(sdo_oe == 1'b0, "R3 oe idle", {31'h0, sdo_oe}, 32'h0);
        model(32'h0, 0);
    endtask

    task automatic t_write_read;
        frame({16'h0, wr(4'd3, 2'd0, 8'h3C)}, 16, "R5 write b0");
        diag_i = 12'h0C7;
        frame({16'h0, wr(4'd9, 2'd1, 8'hA5)}, 16, "R4 write b1 diag");
        frame({16'h0, rd(4'd3, 2'd0)}, 16, "R11 read b0");
        frame({16'h0, rd(4'd9, 2'd1)}, 16, "R6 read reply");
        frame({16'h0, 16'h7FFD}, 16, "R6 read reply b1");
        frame({16'h0, 16'h0001}, 16, "R7 diag read");
        frame({16'h0, rd(4'd0, 2'd0)}, 16, "R7 diag reply");
        frame({16'h0, 16'h0001}, 16, "R6 read zero reg");
    endtask

    task automatic t_frame_len;
        frame({16'h0, wr(4'd1, 2'd0, 8'h11)}[11:0], 12, "R2 twelve clocks");
        frame(32'h00AA, 8, "R2 error reply 8");
        frame({12'h0, wr(4'd1, 2'd0, 8'h22), 4'h0}, 20, "R2 error reply 20");
        frame(32'h0001, 16, "R2 error reply");
        frame(32'h0001, 16, "R2 recovered");
    endtask

    task automatic t_syntax;
        frame({16'h0, 16'hC3FF}, 16, "R8 prefix 11");
        frame({16'h0, 16'h0C02}, 16, "R8 reply prefix 11");
        frame({16'h0, wr(4'd12, 2'd0, 8'h77)}, 16, "R8 reply prefix 00");
        frame({16'h0, rd(4'd2, 2'd2)}, 16, "R8 reply bad index");
        frame({16'h0, 16'h4C03}, 16, "R8 reply bad bank");
        frame({16'h0, rd(4'hF, 2'd3)}, 16, "R8 reply bad tail");
        frame(32'h0001, 16, "R8 reply reset addr read");
    endtask

    task automatic t_soft_reset;
        frame({16'h0, wr(4'd5, 2'd1, 8'h5E)}, 16, "R9 prep");
        frame({16'h0, wr(4'hF, 2'd3, 8'h00)}, 16, "R9 soft reset");
        frame(32'h0001, 16, "R9 reset reply");
    endtask

    task automatic t_daisy;
        logic [31:0] d;
        d = {8'h00, 8'hA7, wr(4'd4, 2'd0, 8'hC9)};
        frame(d, 24, "R10 24-bit frame");
        chk(got[7:0] == 8'hA7, "R10 pass-through 24", {24'h0, got[7:0]}, 32'hA7);
        d = {16'h96E1, rd(4'd4, 2'd0)};
        frame(d, 32, "R10 32-bit frame");
        chk(got[15:0] == 16'h96E1, "R10 pass-through 32",
            {16'h0, got[15:0]}, 32'h96E1);
        frame(32'h0001, 16, "R10 last 16 bits used");
    endtask

    initial begin
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        sdi    = 1'b0;
        diag_i = 12'h5A3;
        exp_reply = 16'h2000;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < NR; i++) mreg[b][i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_oe();
        t_write_read();
        t_frame_len();
        t_syntax();
        t_soft_reset();
        t_daisy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule